// File: doc/BRIEF.md
# Edge Latching Interrupt Controller

This block gathers six interrupt source lines into a sticky status register and turns that register into a single interrupt request for a host. Each source line is first brought into the block's clock domain. While its enable bit is set, a rising edge on the line latches a status bit to 1, and the bit stays at 1. There is no clear register. Software clears a status bit by writing 0 to that bit of the enable register, and it can set the bit to 1 again later.

An interrupt event is the step of the whole status register from all zero to non-zero. A small state machine with three states tracks events. RQ_QUIET means status is zero. RQ_RAISE is the first cycle after an event. RQ_HOLD means status is still non-zero after RQ_RAISE. Its transitions are:

- QUIET→RAISE when status is non-zero.
- RAISE→HOLD when status stays non-zero.
- RAISE→QUIET when status is zero.
- HOLD→QUIET when status is zero.
- HOLD→HOLD otherwise.

The parameter `LEVEL_IRQ` picks the request style. With `LEVEL_IRQ` = 1 the request is high in RAISE and HOLD. With `LEVEL_IRQ` = 0 the request is a one-cycle pulse in RAISE.

Software reaches the block over a simple register bus. Writes are synchronous and reads are combinational. Besides the raw status, the bus offers a packed word built from a programmable channel list. Bit j of that word is the status bit of list entry j, for each j below the programmed count.

Top module: `edge_latch_irq_ctrl`

## Requirements
- R1: Reset clears the enable register, the status register, the channel list and its count, and holds `irq_o` low. Address 0 reads back the enable register in bits 5:0, and a write to address 0 loads it from `wr_data[5:0]`.
- R2: Each `src_i` bit passes through a two-stage synchroniser, and a third stage detects its rising edge. A rise applied before clock edge A sets the status bit at edge A+2. Once set, the bit stays at 1 while it remains enabled, whatever the source does.
- R3: A rising edge that is detected while its source is disabled is ignored. Enabling the source later does not set the status bit.
- R4: A status bit is forced to 0 at the edge where a write clears its enable bit. A write to address 1 has no effect on status.
- R5: A detected rising edge and a write that disables the same source at the same clock edge leave the status bit at 0. Disabling a different source at that edge does not stop the bit from being set.
- R6: An interrupt event is the status register going from all zero to non-zero. No new event occurs while status stays non-zero, even if more status bits are set.
- R7: With `LEVEL_IRQ`=1, `irq_o` is high in the cycle after any cycle in which status is non-zero, and low in the cycle after any cycle in which status is zero.
- R8: With `LEVEL_IRQ`=0, each event gives exactly one one-cycle pulse on `irq_o`, one cycle after status becomes non-zero. A later event needs status to go back to zero first.
- R9: Address 1 reads the status register in bits 5:0, with bits 15:6 read as zero.
- R10: The channel list holds six 3-bit channel indices and a count, set up as follows:
  - A write to address 2 loads entries 0–4 from `wr_data` bits [3j+2:3j].
  - A write to address 3 loads entry 5 from `wr_data[2:0]` and the count from `wr_data[6:4]`.
  - Reading address 3 returns entry 5 and the count in the same layout.
  - Reading address 2 returns the packed word. Bit j (j < count and j < 6) holds the status bit at entry j's index, or 0 if that index is 6 or 7. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Asynchronous interrupt source lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq_o | output | 1 | Host interrupt request (level or pulse) |

## Verification
Two of the block's functions can fall on the same clock edge:

- the latching of a newly detected source edge;
- a software write that clears the enable bit for that same source.

The bench sets a source high, counts the synchroniser stages, and lands the enable write on the exact edge where the rise is latched. The status bit must read 0 afterwards. A control run disables a different source at that same edge, and there the bit must latch. The request output is also timed against clear-by-disable: the level request must stay high for exactly one cycle after status reads zero, and the pulse count must not grow while status stays non-zero.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int NSRC    = 6;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int IDX_W   = 3;
    localparam int CNT_LSB = 4;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LIST_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_LIST_HI = 2'd3;

    typedef enum logic [1:0] {
        RQ_QUIET = 2'd0,
        RQ_RAISE = 2'd1,
        RQ_HOLD  = 2'd2
    } rq_state_e;

endpackage

// File: rtl/src_sync.sv
module src_sync #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic stg1_q, stg2_q, stg3_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg1_q <= 1'b0;
                stg2_q <= 1'b0;
                stg3_q <= 1'b0;
            end else begin
                stg1_q <= src_i[i];
                stg2_q <= stg1_q;
                stg3_q <= stg2_q;
            end
        end

        assign rise_o[i] = stg2_q & ~stg3_q;
    end

endmodule

// File: rtl/status_latch.sv
module status_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic [N-1:0] rise_i,
    output logic [N-1:0] en_q,
    output logic [N-1:0] status_q
);

    logic [N-1:0] en_d;
    logic [N-1:0] status_d;

    // New enable value takes effect at the same edge as any latch, so a
    // disable arriving together with a detected rise leaves the bit at 0.
    always_comb begin
        en_d     = en_wr ? en_wdata : en_q;
        status_d = en_d & (status_q | (rise_i & en_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            status_q <= '0;
        end else begin
            en_q     <= en_d;
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/rq_fsm.sv
module rq_fsm
    import irq_latch_pkg::*;
#(
    parameter bit LEVEL_IRQ = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic status_any,
    output logic irq_o
);

    rq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_QUIET: if (status_any) state_d = RQ_RAISE;
            RQ_RAISE: state_d = status_any ? RQ_HOLD : RQ_QUIET;
            RQ_HOLD:  if (!status_any) state_d = RQ_QUIET;
            default:  state_d = RQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        if (LEVEL_IRQ) irq_o = (state_q != RQ_QUIET);
        else           irq_o = (state_q == RQ_RAISE);
    end

endmodule

// File: rtl/list_pack.sv
module list_pack #(
    parameter int N       = 6,
    parameter int IDX_W   = 3,
    parameter int OUT_W   = 16,
    parameter int LO_ENT  = 5,
    localparam int LIST_BITS = N * IDX_W,
    localparam int LO_BITS   = LO_ENT * IDX_W,
    localparam int HI_BITS   = LIST_BITS - LO_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_wr,
    input  logic [LO_BITS-1:0]   lo_data,
    input  logic                 hi_wr,
    input  logic [HI_BITS-1:0]   hi_data,
    input  logic [IDX_W-1:0]     cnt_data,
    input  logic [N-1:0]         status_i,
    output logic [HI_BITS-1:0]   hi_q,
    output logic [IDX_W-1:0]     cnt_q,
    output logic [OUT_W-1:0]     packed_o
);

    logic [LIST_BITS-1:0] list_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (lo_wr) list_q[LO_BITS-1:0] <= lo_data;
            if (hi_wr) begin
                list_q[LIST_BITS-1:LO_BITS] <= hi_data;
                cnt_q                       <= cnt_data;
            end
        end
    end

    assign hi_q = list_q[LIST_BITS-1:LO_BITS];

    always_comb begin
        logic [IDX_W-1:0] idx;
        packed_o = '0;
        for (int j = 0; j < N; j++) begin
            idx = list_q[j*IDX_W +: IDX_W];
            if (j < int'(cnt_q) && int'(idx) < N) packed_o[j] = status_i[idx];
        end
    end

endmodule

// File: rtl/edge_latch_irq_ctrl.sv
module edge_latch_irq_ctrl
    import irq_latch_pkg::*;
#(
    parameter bit LEVEL_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_o
);

    localparam int LO_ENT    = REG_W / IDX_W;
    localparam int LO_BITS   = LO_ENT * IDX_W;
    localparam int HI_BITS   = NSRC * IDX_W - LO_BITS;

    logic [NSRC-1:0]    rise;
    logic [NSRC-1:0]    en_q;
    logic [NSRC-1:0]    status_q;
    logic [HI_BITS-1:0] list_hi;
    logic [IDX_W-1:0]   list_cnt;
    logic [REG_W-1:0]   packed_word;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    src_sync #(.N(NSRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    status_latch #(.N(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (wr_en && wr_addr == A_ENABLE),
        .en_wdata (wr_data[NSRC-1:0]),
        .rise_i   (rise),
        .en_q     (en_q),
        .status_q (status_q)
    );

    rq_fsm #(.LEVEL_IRQ(LEVEL_IRQ)) u_rq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_any (|status_q),
        .irq_o      (irq_o)
    );

    list_pack #(.N(NSRC), .IDX_W(IDX_W), .OUT_W(REG_W), .LO_ENT(LO_ENT)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_wr    (wr_en && wr_addr == A_LIST_LO),
        .lo_data  (wr_data[LO_BITS-1:0]),
        .hi_wr    (wr_en && wr_addr == A_LIST_HI),
        .hi_data  (wr_data[HI_BITS-1:0]),
        .cnt_data (wr_data[CNT_LSB +: IDX_W]),
        .status_i (status_q),
        .hi_q     (list_hi),
        .cnt_q    (list_cnt),
        .packed_o (packed_word)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_ENABLE:  rd_data[NSRC-1:0] = en_q;
            A_STATUS:  rd_data[NSRC-1:0] = status_q;
            A_LIST_LO: rd_data = packed_word;
            A_LIST_HI: begin
                rd_data[HI_BITS-1:0]       = list_hi;
                rd_data[CNT_LSB +: IDX_W]  = list_cnt;
            end
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_latch_pkg::*;
#(
    parameter bit LEVEL_IRQ = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   status_q,
    input logic              irq_o
);

    // R2: an enabled status bit never falls back to 0
    a_r2_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_q) & en_q) & ~status_q) == '0));

    // R4: no status bit is set while its source is disabled
    a_r4_status_within_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~en_q) == '0));

    // R5: an enable write clears the disabled bits at that edge, rise or not
    a_r5_disable_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ENABLE) |=> ((status_q & ~$past(wr_data[NSRC-1:0])) == '0));

    if (LEVEL_IRQ) begin : g_level
        a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q != '0) |=> irq_o);
        a_r7_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q == '0) |=> !irq_o);
    end else begin : g_edge
        a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |=> !irq_o);
        a_r8_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> ($past(status_q) != '0 && $past(status_q, 2) == '0));
    end

endmodule

bind edge_latch_irq_ctrl irq_ctrl_chk #(.LEVEL_IRQ(LEVEL_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .en_q     (en_q),
    .status_q (status_q),
    .irq_o    (irq_o)
);

// File: tb/tb_edge_latch_irq_ctrl.sv
module tb_edge_latch_irq_ctrl;
    import irq_latch_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [REG_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [REG_W-1:0]  rd_data, rd_data_e;
    logic              irq_lvl, irq_pls;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    edge_latch_irq_ctrl #(.LEVEL_IRQ(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_lvl));

    edge_latch_irq_ctrl #(.LEVEL_IRQ(1'b0)) dut_e (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_e), .irq_o(irq_pls));

    always @(negedge clk) if (rst_n && irq_pls) pulses++;

    // {enable, source pattern, expected status}
    localparam logic [17:0] VEC [0:7] = '{
        {6'h3F, 6'h01, 6'h01},
        {6'h3F, 6'h24, 6'h25},
        {6'h3E, 6'h00, 6'h24},
        {6'h0F, 6'h30, 6'h04},
        {6'h3F, 6'h00, 6'h04},
        {6'h3F, 6'h1A, 6'h1E},
        {6'h00, 6'h3F, 6'h00},
        {6'h3F, 6'h3F, 6'h3F}
    };

    task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [REG_W-1:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(A_ENABLE, v);  chk("R1 enable after reset", v, 16'h0000);
        rd(A_STATUS, v);  chk("R1 status after reset", v, 16'h0000);
        rd(A_LIST_HI, v); chk("R1 list count after reset", v, 16'h0000);
        rd(A_LIST_LO, v); chk("R1 packed after reset", v, 16'h0000);
        chk("R1 irq after reset", {15'd0, irq_lvl | irq_pls}, 16'h0000);

        // Table walk: R2 R3 R4 R9 R7
        for (int k = 0; k < 8; k++) begin
            wr(A_ENABLE, {10'd0, VEC[k][17:12]});
            rd(A_ENABLE, v); chk("R1 enable readback", v, {10'd0, VEC[k][17:12]});
            src = VEC[k][11:6];
            repeat (4) @(negedge clk);
            src = '0;
            repeat (4) @(negedge clk);
            rd(A_STATUS, v); chk("R2/R3/R4/R9 status vector", v, {10'd0, VEC[k][5:0]});
            chk("R7 level follows status", {15'd0, irq_lvl}, {15'd0, VEC[k][5:0] != 6'd0});
        end

        // R6 R7 R8: event timing
        wr(A_ENABLE, 16'h0000);
        wr(A_ENABLE, 16'h003F);
        repeat (2) @(negedge clk);
        p0 = pulses;
        src = 6'h01;
        repeat (3) @(negedge clk);
        rd(A_STATUS, v); chk("R2 status set two edges after sync", v, 16'h0001);
        chk("R7 level not yet high", {15'd0, irq_lvl}, 16'h0000);
        @(negedge clk);
        chk("R7 level high after event", {15'd0, irq_lvl}, 16'h0001);
        chk("R8 pulse high after event", {15'd0, irq_pls}, 16'h0001);
        @(negedge clk);
        chk("R8 pulse one cycle", {15'd0, irq_pls}, 16'h0000);
        src = 6'h03;
        repeat (6) @(negedge clk);
        rd(A_STATUS, v); chk("R2 second bit set", v, 16'h0003);
        chk("R6 no new event while nonzero", pulses - p0, 1);
        chk("R7 level held", {15'd0, irq_lvl}, 16'h0001);
        src = '0;
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ENABLE; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_STATUS, v); chk("R4 disable clears status", v, 16'h0000);
        chk("R7 level lags clear by one cycle", {15'd0, irq_lvl}, 16'h0001);
        @(negedge clk);
        chk("R7 level low after clear", {15'd0, irq_lvl}, 16'h0000);
        wr(A_ENABLE, 16'h003F);
        src = 6'h04;
        repeat (6) @(negedge clk);
        chk("R8 re-armed event pulses again", pulses - p0, 2);

        // R5: rise and disable at the same edge
        src = 6'h0C;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ENABLE; wr_data = 16'h0037;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_STATUS, v); chk("R5 disable wins over same-edge rise", v, 16'h0004);
        wr(A_ENABLE, 16'h003F);
        repeat (4) @(negedge clk);
        rd(A_STATUS, v); chk("R3 consumed edge not latched later", v, 16'h0004);
        src = 6'h04;
        repeat (4) @(negedge clk);
        src = 6'h0C;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ENABLE; wr_data = 16'h003D;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_STATUS, v); chk("R5 other-bit disable keeps latch", v, 16'h000C);

        // R4: status address is not writable
        wr(A_STATUS, 16'h0000);
        rd(A_STATUS, v); chk("R4 status write ignored (zero)", v, 16'h000C);
        wr(A_STATUS, 16'h003F);
        rd(A_STATUS, v); chk("R4 status write ignored (ones)", v, 16'h000C);

        // R10: packed readout, status = 0C
        wr(A_LIST_LO, 16'h7A83);
        wr(A_LIST_HI, 16'h0062);
        rd(A_LIST_HI, v); chk("R10 list high readback", v, 16'h0062);
        rd(A_LIST_LO, v); chk("R10 packed six entries", v, 16'h0025);
        wr(A_LIST_HI, 16'h0022);
        rd(A_LIST_LO, v); chk("R10 packed count two", v, 16'h0001);
        wr(A_LIST_HI, 16'h0002);
        rd(A_LIST_LO, v); chk("R10 packed count zero", v, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule